// File: doc/BRIEF.md
# Dual-Pixel Output Formatter with Stagger

This block sits behind a link decoder and turns a stream of decoded pixels into the buses a flat-panel timing controller expects. It runs from an internal clock at twice the pixel rate. Each input pixel and its control bits (data enable, horizontal and vertical sync, three general control bits) are held for two internal cycles and sampled on the second. In single-pixel mode every pixel is placed on the even bus. In dual-pixel mode consecutive pixels are paired, with the first on the even bus and the second on the odd bus, and the output clock runs at half the pixel rate.

In dual-pixel mode the odd bus can be delayed by one internal cycle, which is a quarter of the output-clock period. This spreads the switching of the two buses. A clock-invert input changes only the phase of the output clock. Two active-low power-down inputs drive output-enable flags that stand in for pad tri-state control. A colour-depth parameter places narrow colour components at the top of each byte lane.

Top module: `dual_pixel_fmt`

## Requirements
- R1: With dual_i low, each sampled pixel appears on even_o at the sampling edge, and odd_o is all zeros.
- R2: With dual_i high, the first pixel of a pair is held. At the edge that samples the second pixel, even_o shows the first pixel. With stag_n_i high, odd_o shows the second pixel at that same edge.
- R3: With dual_i high and stag_n_i low, odd_o keeps its old value at the pair edge and takes the second pixel one internal cycle later.
- R4: With dual_i low, stag_n_i has no effect: even_o updates at the sampling edge and odd_o stays zero.
- R5: In single-pixel mode the internal output clock toggles every internal cycle and is high after each sampling edge. In dual-pixel mode it is high for the two internal cycles after a pair edge and low until the next pair edge.
- R6: clk_inv_i high inverts oclk_o and leaves the data and control outputs unchanged.
- R7: The first pixel sampled with de_i high after a sample with de_i low is always treated as the first pixel of a pair. A half-formed pair from blanking is dropped and produces no pair edge.
- R8: de_o, hs_o, vs_o and ctl_o change together with even_o. In dual-pixel mode they carry the control bits sampled with the first pixel of the pair.
- R9: pd_n_i low clears both oe_main_o and oe_ctl1_o one internal cycle later.
- R10: pdo_n_i low with pd_n_i high clears oe_main_o one cycle later and keeps oe_ctl1_o high. Both flags are high one cycle after both inputs are high.
- R11: With CBITS below LANE_W, each colour field is MSB-justified in its lane and the low bits are zero. Lanes are blue at bits 7:0, green at 15:8 and red at 23:16 for the default lane width. The input is packed in the same order with CBITS per colour.
- R12: During reset both buses and all control outputs are zero, the internal output clock is high, both enable flags are low, and the first edge after release is a non-sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the pixel rate |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_i | input | 3*CBITS | Packed pixel, blue in the low field |
| de_i | input | 1 | Data enable for the pixel |
| hs_i | input | 1 | Horizontal sync |
| vs_i | input | 1 | Vertical sync |
| ctl_i | input | 3 | General control bits, bit 0 is control 1 |
| dual_i | input | 1 | High selects two pixels per output clock |
| stag_n_i | input | 1 | Low delays the odd bus in dual-pixel mode |
| clk_inv_i | input | 1 | High inverts the output clock |
| pd_n_i | input | 1 | Global power-down, active low |
| pdo_n_i | input | 1 | Output power-down, active low |
| even_o | output | 3*LANE_W | Even pixel bus |
| odd_o | output | 3*LANE_W | Odd pixel bus |
| oclk_o | output | 1 | Output data clock |
| de_o | output | 1 | Aligned data enable |
| hs_o | output | 1 | Aligned horizontal sync |
| vs_o | output | 1 | Aligned vertical sync |
| ctl_o | output | 3 | Aligned control bits |
| oe_main_o | output | 1 | Enable for buses, clock, DE, syncs, controls 2 and 3 |
| oe_ctl1_o | output | 1 | Enable for control bit 1 |

## Verification
The hardest case to reach from the ports is the realignment at the start of a line. The pair counter must be mid-pair, with one blanking pixel already held, at the moment data enable rises. The stimulus reaches this state by sending an odd number of blanking pixels in dual-pixel mode and then raising de_i. The bench then checks that no pair edge occurs and that the next pair starts with the new pixel. The one-cycle lag of the staggered odd bus is caught by sampling odd_o between the two internal edges of the following pixel slot.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
    typedef struct packed {
        logic       de;
        logic       hs;
        logic       vs;
        logic [2:0] ctl;
    } ctrl_t;
endpackage

// File: rtl/fmt_lane_pack.sv
module fmt_lane_pack #(
    parameter int CBITS  = 8,
    parameter int LANE_W = 8
) (
    input  logic [3*CBITS-1:0]  narrow_i,
    output logic [3*LANE_W-1:0] wide_o
);
    localparam int PAD_W = LANE_W - CBITS;

    for (genvar g = 0; g < 3; g++) begin : g_lane
        assign wide_o[g*LANE_W+LANE_W-1 -: CBITS] = narrow_i[g*CBITS+CBITS-1 -: CBITS];
        if (PAD_W > 0) begin : g_pad
            assign wide_o[g*LANE_W +: PAD_W] = '0;
        end
    end
endmodule

// File: rtl/fmt_pair_engine.sv
module fmt_pair_engine
    import fmt_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pix_i,
    input  ctrl_t        ctrl_i,
    input  logic         dual_i,
    input  logic         stag_n_i,
    output logic [W-1:0] even_o,
    output logic [W-1:0] odd_o,
    output ctrl_t        ctrl_o,
    output logic         oclk_o
);
    typedef struct packed {
        logic         half;
        logic         slot;
        logic         de_prev;
        logic [W-1:0] hold_pix;
        ctrl_t        hold_ctl;
        logic [W-1:0] even;
        logic [W-1:0] odd;
        logic [W-1:0] odd_pend;
        logic         stag_due;
        ctrl_t        ctl_out;
        logic         oclk;
    } eng_t;

    eng_t st_d, st_q;
    logic take, emit, de_rise, cur_slot;

    always_comb begin
        st_d     = st_q;
        st_d.half = ~st_q.half;
        take     = st_q.half;
        emit     = 1'b0;
        de_rise  = 1'b0;
        cur_slot = 1'b0;
        st_d.stag_due = 1'b0;
        if (st_q.stag_due) st_d.odd = st_q.odd_pend;
        if (take) begin
            de_rise      = ctrl_i.de & ~st_q.de_prev;
            st_d.de_prev = ctrl_i.de;
            if (!dual_i) begin
                emit         = 1'b1;
                st_d.even    = pix_i;
                st_d.ctl_out = ctrl_i;
                st_d.slot    = 1'b0;
            end else begin
                cur_slot  = de_rise ? 1'b0 : st_q.slot;
                st_d.slot = ~cur_slot;
                if (!cur_slot) begin
                    st_d.hold_pix = pix_i;
                    st_d.hold_ctl = ctrl_i;
                end else begin
                    emit         = 1'b1;
                    st_d.even    = st_q.hold_pix;
                    st_d.ctl_out = st_q.hold_ctl;
                    if (!stag_n_i) begin
                        st_d.odd_pend = pix_i;
                        st_d.stag_due = 1'b1;
                    end else begin
                        st_d.odd = pix_i;
                    end
                end
            end
        end
        if (!dual_i) begin
            st_d.odd  = '0;
            st_d.oclk = st_q.half;
        end else begin
            st_d.oclk = emit ? 1'b1 : (st_q.half ? 1'b0 : st_q.oclk);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.oclk <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign even_o = st_q.even;
    assign odd_o  = st_q.odd;
    assign ctrl_o = st_q.ctl_out;
    assign oclk_o = st_q.oclk;

    // R1
    odd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_i && $past(!dual_i) && $past(rst_n)) |-> (odd_o == '0));

    // R5
    oclk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_i && $past(!dual_i) && $past(!dual_i, 2) && $past(rst_n))
        |-> (oclk_o != $past(oclk_o)));

    // R3
    stag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && dual_i && !stag_n_i) |=> $stable(odd_o));
endmodule

// File: rtl/fmt_oe_ctrl.sv
module fmt_oe_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n_i,
    input  logic pdo_n_i,
    output logic oe_main_o,
    output logic oe_ctl1_o
);
    typedef struct packed {
        logic main;
        logic ctl1;
    } oe_t;

    oe_t oe_d, oe_q;

    always_comb begin
        oe_d.main = pd_n_i & pdo_n_i;
        oe_d.ctl1 = pd_n_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) oe_q <= '0;
        else        oe_q <= oe_d;
    end

    assign oe_main_o = oe_q.main;
    assign oe_ctl1_o = oe_q.ctl1;

    // R9
    pd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n_i |=> (!oe_main_o && !oe_ctl1_o));

    // R10
    pdo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n_i && !pdo_n_i) |=> (!oe_main_o && oe_ctl1_o));
endmodule

// File: rtl/dual_pixel_fmt.sv
module dual_pixel_fmt
    import fmt_pkg::*;
#(
    parameter int CBITS  = 8,
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3*CBITS-1:0]  pix_i,
    input  logic                de_i,
    input  logic                hs_i,
    input  logic                vs_i,
    input  logic [2:0]          ctl_i,
    input  logic                dual_i,
    input  logic                stag_n_i,
    input  logic                clk_inv_i,
    input  logic                pd_n_i,
    input  logic                pdo_n_i,
    output logic [3*LANE_W-1:0] even_o,
    output logic [3*LANE_W-1:0] odd_o,
    output logic                oclk_o,
    output logic                de_o,
    output logic                hs_o,
    output logic                vs_o,
    output logic [2:0]          ctl_o,
    output logic                oe_main_o,
    output logic                oe_ctl1_o
);
    localparam int OUT_W = 3 * LANE_W;

    logic [OUT_W-1:0] wide_pix;
    ctrl_t            ctrl_in, ctrl_out;
    logic             oclk_int;

    assign ctrl_in = '{de: de_i, hs: hs_i, vs: vs_i, ctl: ctl_i};

    fmt_lane_pack #(.CBITS(CBITS), .LANE_W(LANE_W)) u_pack (
        .narrow_i (pix_i),
        .wide_o   (wide_pix)
    );

    fmt_pair_engine #(.W(OUT_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_i    (wide_pix),
        .ctrl_i   (ctrl_in),
        .dual_i   (dual_i),
        .stag_n_i (stag_n_i),
        .even_o   (even_o),
        .odd_o    (odd_o),
        .ctrl_o   (ctrl_out),
        .oclk_o   (oclk_int)
    );

    fmt_oe_ctrl u_oe (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd_n_i    (pd_n_i),
        .pdo_n_i   (pdo_n_i),
        .oe_main_o (oe_main_o),
        .oe_ctl1_o (oe_ctl1_o)
    );

    assign oclk_o = oclk_int ^ clk_inv_i;
    assign de_o   = ctrl_out.de;
    assign hs_o   = ctrl_out.hs;
    assign vs_o   = ctrl_out.vs;
    assign ctl_o  = ctrl_out.ctl;
endmodule

// File: tb/sim_dual_pixel_fmt.sv
module sim_dual_pixel_fmt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] pix = '0;
    logic        de = 1'b0, hs = 1'b0, vs = 1'b0;
    logic [2:0]  ctl = '0;
    logic        dual = 1'b0, stag_n = 1'b1, inv = 1'b0;
    logic        pd_n = 1'b1, pdo_n = 1'b1;

    logic [23:0] even, odd, even6, odd6;
    logic        oclk, de_o, hs_o, vs_o, oe_m, oe_c1;
    logic        oclk6, de6, hs6, vs6, oe_m6, oe_c16;
    logic [2:0]  ctl_o, ctl6;
    logic [17:0] pix6;

    int n_tests = 0;
    int n_fail  = 0;
    logic        mid_oclk;
    logic [23:0] mid_odd;

    always #2 clk = ~clk;

    assign pix6 = {pix[23:18], pix[15:10], pix[7:2]};

    dual_pixel_fmt u0 (
        .clk(clk), .rst_n(rst_n), .pix_i(pix), .de_i(de), .hs_i(hs), .vs_i(vs),
        .ctl_i(ctl), .dual_i(dual), .stag_n_i(stag_n), .clk_inv_i(inv),
        .pd_n_i(pd_n), .pdo_n_i(pdo_n), .even_o(even), .odd_o(odd), .oclk_o(oclk),
        .de_o(de_o), .hs_o(hs_o), .vs_o(vs_o), .ctl_o(ctl_o),
        .oe_main_o(oe_m), .oe_ctl1_o(oe_c1)
    );

    dual_pixel_fmt #(.CBITS(6), .LANE_W(8)) u1 (
        .clk(clk), .rst_n(rst_n), .pix_i(pix6), .de_i(de), .hs_i(hs), .vs_i(vs),
        .ctl_i(ctl), .dual_i(dual), .stag_n_i(stag_n), .clk_inv_i(inv),
        .pd_n_i(pd_n), .pdo_n_i(pdo_n), .even_o(even6), .odd_o(odd6), .oclk_o(oclk6),
        .de_o(de6), .hs_o(hs6), .vs_o(vs6), .ctl_o(ctl6),
        .oe_main_o(oe_m6), .oe_ctl1_o(oe_c16)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send(input logic [23:0] p, input logic d, input logic h);
        pix = p; de = d; hs = h;
        @(posedge clk);
        @(negedge clk);
        mid_oclk = oclk;
        mid_odd  = odd;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) cyc();
        check("R12 even", even, 0);
        check("R12 odd", odd, 0);
        check("R12 de", de_o, 0);
        check("R12 oclk", oclk, 1);
        check("R12 oe", {oe_m, oe_c1}, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_one_pixel();
        send(24'h123456, 1'b1, 1'b1);
        check("R1 even", even, 24'h123456);
        check("R1 odd", odd, 0);
        check("R8 de", de_o, 1);
        check("R8 hs", hs_o, 1);
        check("R11 narrow", even6, 24'h123456 & 24'hFCFCFC);
        check("R5 oclk high", oclk, 1);
        cyc();
        check("R5 oclk low", oclk, 0);
        cyc();
        send(24'hA5C3E7, 1'b1, 1'b0);
        check("R1 even2", even, 24'hA5C3E7);
        check("R8 hs low", hs_o, 0);
        check("R11 narrow2", even6, 24'hA5C3E7 & 24'hFCFCFC);
    endtask

    task automatic t_stag_ignored();
        stag_n = 1'b0;
        send(24'h0F1E2D, 1'b1, 1'b0);
        check("R4 even", even, 24'h0F1E2D);
        check("R4 odd", odd, 0);
        cyc();
        check("R4 odd later", odd, 0);
        cyc();
        stag_n = 1'b1;
    endtask

    task automatic t_pair_realign();
        dual = 1'b1;
        send(24'h111111, 1'b0, 1'b0);
        send(24'h222222, 1'b0, 1'b0);
        check("R2 even", even, 24'h111111);
        check("R2 odd", odd, 24'h222222);
        check("R5 oclk pair", oclk, 1);
        send(24'h333333, 1'b0, 1'b0);
        check("R5 oclk mid", mid_oclk, 1);
        check("R5 oclk low", oclk, 0);
        send(24'h444444, 1'b1, 1'b1);
        check("R7 no pair edge", even, 24'h111111);
        check("R7 oclk held low", oclk, 0);
        send(24'h555555, 1'b1, 1'b0);
        check("R7 realigned even", even, 24'h444444);
        check("R7 realigned odd", odd, 24'h555555);
        check("R8 de aligned", de_o, 1);
        check("R8 hs of first", hs_o, 1);
    endtask

    task automatic t_stagger();
        stag_n = 1'b0;
        send(24'h666666, 1'b1, 1'b0);
        send(24'h777777, 1'b1, 1'b0);
        check("R3 even now", even, 24'h666666);
        check("R3 odd old", odd, 24'h555555);
        stag_n = 1'b1;
        send(24'h888888, 1'b1, 1'b0);
        check("R3 odd late", mid_odd, 24'h777777);
    endtask

    task automatic t_invert();
        inv = 1'b1;
        send(24'h999999, 1'b1, 1'b0);
        check("R6 even", even, 24'h888888);
        check("R6 odd", odd, 24'h999999);
        check("R6 oclk inv", oclk, 0);
        inv = 1'b0;
    endtask

    task automatic t_power();
        pdo_n = 1'b0;
        cyc();
        check("R10 main off", oe_m, 0);
        check("R10 ctl1 on", oe_c1, 1);
        pdo_n = 1'b1; pd_n = 1'b0;
        cyc();
        check("R9 main off", oe_m, 0);
        check("R9 ctl1 off", oe_c1, 0);
        pd_n = 1'b1;
        cyc();
        check("R10 both on", {oe_m, oe_c1}, 2'b11);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_one_pixel();
        t_stag_ignored();
        t_pair_realign();
        t_stagger();
        t_invert();
        t_power();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule